// File: doc/BRIEF.md
# Single-Slot Processor-to-Processor Mailbox

This block passes one message at a time from a sending processor to a receiving processor. A message is a pointer into memory that both processors can read, plus a command word that says what to do with it. Each processor has its own small register port with a write strobe, a two-bit register offset, write data and combinational read data.

The sender first writes the pointer into a staging register and then writes the command word. Writing the command word commits the message and makes it pending. The receiver learns of the message either from its interrupt line or by polling a status bit. It reads the pointer and the command, then writes to a dedicated release register, which frees the slot.

The sender can optionally take an interrupt while the slot is free. While the slot holds a message, the sender cannot write message words. Any such attempt is dropped and recorded in a sticky overflow flag.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the slot is empty, the overflow flag and both interrupt enables are 0, and both interrupt outputs are low.
- R2: A sender write to offset 1 (command) while the slot is empty makes the slot pending. From the next cycle, the receiver reads the staged pointer at offset 0 and the command, zero-extended, at offset 1.
- R3: A sender write to offset 0 (pointer) while the slot is empty only updates the staging register, which the sender reads back at offset 0. It does not make a message pending, and a later pointer write replaces the staged value.
- R4: Receiver status at offset 2 shows the pending state in bit 0, so the receiver can poll it with no interrupt enabled.
- R5: The receiver interrupt is high exactly while a message is pending and the receiver enable is set. The receiver enable is bit 1 of receiver offset 2, is written through bit 0 of that offset, and reads back in bit 1.
- R6: Any receiver write to offset 3 (release) empties the slot at that clock edge, so status bit 0 and the receiver interrupt are 0 in the following cycle.
- R7: A sender write to offset 0 or offset 1 while a message is pending is ignored. The held pointer, the held command and the staging register stay as they were, and the overflow flag (sender status bit 1) is set.
- R8: The overflow flag stays set until the sender writes offset 2 with bit 1 equal to 1. A write to offset 2 with bit 1 equal to 0 leaves the flag set.
- R9: The sender interrupt is high exactly while the slot is empty and the sender enable is set. The sender enable is bit 2 of sender offset 2 and is written and read there. Sender status bit 0 mirrors the pending state.
- R10: If a sender command write and a receiver release fall in the same cycle while the slot is pending, the command is ignored and the overflow flag is set. The slot is empty in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_we | input | 1 | Sender write strobe |
| tx_addr | input | 2 | Sender register offset |
| tx_wdata | input | DATA_W | Sender write data |
| tx_rdata | output | DATA_W | Sender read data for tx_addr |
| tx_irq | output | 1 | Sender interrupt, slot free |
| rx_we | input | 1 | Receiver write strobe |
| rx_addr | input | 2 | Receiver register offset |
| rx_wdata | input | DATA_W | Receiver write data |
| rx_rdata | output | DATA_W | Receiver read data for rx_addr |
| rx_irq | output | 1 | Receiver interrupt, message pending |

## Verification
The hardest situation to reach is a command write that arrives in the same cycle as the receiver's release. In that cycle the slot is still pending, so the command must be dropped, even though the slot is empty one cycle later. The bench drives both write strobes on the same falling edge, so both land on one rising edge. It then reads the receiver status, the sender overflow bit and the sender interrupt. The bench also covers writes made while the slot is full and the sticky overflow flag. It reaches these through a table of write-then-read vectors that first fills the slot and then writes into it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // sender register offsets
   localparam logic [1:0] TX_OFS_PTR  = 2'd0;
   localparam logic [1:0] TX_OFS_CMD  = 2'd1;
   localparam logic [1:0] TX_OFS_STAT = 2'd2;
   // receiver register offsets
   localparam logic [1:0] RX_OFS_PTR  = 2'd0;
   localparam logic [1:0] RX_OFS_CMD  = 2'd1;
   localparam logic [1:0] RX_OFS_STAT = 2'd2;
   localparam logic [1:0] RX_OFS_DONE = 2'd3;
   // status bit positions
   localparam int BIT_FULL = 0;
   localparam int BIT_OVF  = 1;
   localparam int BIT_TXEN = 2;
   localparam int BIT_RXEN = 1;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
   parameter int CMD_W = 16,
   parameter int PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [CMD_W-1:0] cmd_in,
   input  logic [PTR_W-1:0] ptr_in,
   input  logic             release_i,
   output logic             full,
   output logic [CMD_W-1:0] cmd_q,
   output logic [PTR_W-1:0] ptr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full  <= 1'b0;
         cmd_q <= '0;
         ptr_q <= '0;
      end else begin
         if (release_i)
            full <= 1'b0;
         else if (commit)
            full <= 1'b1;
         if (commit) begin
            cmd_q <= cmd_in;
            ptr_q <= ptr_in;
         end
      end
   end

   // R2
   commit_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !release_i) |=> (full && ptr_q == $past(ptr_in) && cmd_q == $past(cmd_in)));
   // R6
   release_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      release_i |=> !full);
   // R7
   held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !release_i) |=> ($stable(ptr_q) && $stable(cmd_q)));
endmodule

// File: rtl/mbx_tx_port.sv
module mbx_tx_port
   import mbx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CMD_W  = 16,
   parameter int PTR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              full,
   output logic              commit,
   output logic [CMD_W-1:0]  cmd_word,
   output logic [PTR_W-1:0]  stage_ptr,
   output logic              tx_en,
   output logic [DATA_W-1:0] rdata
);
   logic ptr_wr, cmd_wr, stat_wr, ovf;
   logic [DATA_W-1:0] ptr_ext;

   assign ptr_wr   = we && (addr == TX_OFS_PTR);
   assign cmd_wr   = we && (addr == TX_OFS_CMD);
   assign stat_wr  = we && (addr == TX_OFS_STAT);
   assign commit   = cmd_wr && !full;
   assign cmd_word = wdata[CMD_W-1:0];

   generate
      if (PTR_W == DATA_W) begin : g_ptr_same
         assign ptr_ext = stage_ptr;
      end else begin : g_ptr_pad
         assign ptr_ext = {{(DATA_W-PTR_W){1'b0}}, stage_ptr};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_ptr <= '0;
         ovf       <= 1'b0;
         tx_en     <= 1'b0;
      end else begin
         if (ptr_wr && !full)
            stage_ptr <= wdata[PTR_W-1:0];
         if ((ptr_wr || cmd_wr) && full)
            ovf <= 1'b1;
         else if (stat_wr && wdata[BIT_OVF])
            ovf <= 1'b0;
         if (stat_wr)
            tx_en <= wdata[BIT_TXEN];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         TX_OFS_PTR: rdata = ptr_ext;
         TX_OFS_STAT: begin
            rdata[BIT_FULL] = full;
            rdata[BIT_OVF]  = ovf;
            rdata[BIT_TXEN] = tx_en;
         end
         default: rdata = '0;
      endcase
   end

   // R7
   full_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ptr_wr || cmd_wr) && full) |=> (ovf && $stable(stage_ptr)));
   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !(stat_wr && wdata[BIT_OVF])) |=> ovf);
endmodule

// File: rtl/mbx_rx_port.sv
module mbx_rx_port
   import mbx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CMD_W  = 16,
   parameter int PTR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              full,
   input  logic [CMD_W-1:0]  cmd_q,
   input  logic [PTR_W-1:0]  ptr_q,
   output logic              release_o,
   output logic              rx_en,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] ptr_ext, cmd_ext;

   generate
      if (PTR_W == DATA_W) begin : g_ptr_same
         assign ptr_ext = ptr_q;
      end else begin : g_ptr_pad
         assign ptr_ext = {{(DATA_W-PTR_W){1'b0}}, ptr_q};
      end
      if (CMD_W == DATA_W) begin : g_cmd_same
         assign cmd_ext = cmd_q;
      end else begin : g_cmd_pad
         assign cmd_ext = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
      end
   endgenerate

   assign release_o = we && (addr == RX_OFS_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n)
         rx_en <= 1'b0;
      else if (we && addr == RX_OFS_STAT)
         rx_en <= wdata[0];
   end

   always_comb begin
      rdata = '0;
      case (addr)
         RX_OFS_PTR: rdata = ptr_ext;
         RX_OFS_CMD: rdata = cmd_ext;
         RX_OFS_STAT: begin
            rdata[BIT_FULL] = full;
            rdata[BIT_RXEN] = rx_en;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
   parameter int DATA_W = 32,
   parameter int CMD_W  = 16,
   parameter int PTR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_we,
   input  logic [1:0]        tx_addr,
   input  logic [DATA_W-1:0] tx_wdata,
   output logic [DATA_W-1:0] tx_rdata,
   output logic              tx_irq,
   input  logic              rx_we,
   input  logic [1:0]        rx_addr,
   input  logic [DATA_W-1:0] rx_wdata,
   output logic [DATA_W-1:0] rx_rdata,
   output logic              rx_irq
);
   generate
      if (DATA_W < 3) begin : g_bad_data
         $error("DATA_W must hold the three status bits");
      end
      if (CMD_W < 1 || CMD_W > DATA_W) begin : g_bad_cmd
         $error("CMD_W must be 1..DATA_W");
      end
      if (PTR_W < 1 || PTR_W > DATA_W) begin : g_bad_ptr
         $error("PTR_W must be 1..DATA_W");
      end
   endgenerate

   logic             commit, release_s, full, tx_en, rx_en;
   logic [CMD_W-1:0] cmd_word, cmd_q;
   logic [PTR_W-1:0] stage_ptr, ptr_q;

   mbx_tx_port #(.DATA_W(DATA_W), .CMD_W(CMD_W), .PTR_W(PTR_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .we(tx_we), .addr(tx_addr), .wdata(tx_wdata),
      .full(full), .commit(commit), .cmd_word(cmd_word), .stage_ptr(stage_ptr),
      .tx_en(tx_en), .rdata(tx_rdata));

   mbx_slot #(.CMD_W(CMD_W), .PTR_W(PTR_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .commit(commit), .cmd_in(cmd_word),
      .ptr_in(stage_ptr), .release_i(release_s), .full(full),
      .cmd_q(cmd_q), .ptr_q(ptr_q));

   mbx_rx_port #(.DATA_W(DATA_W), .CMD_W(CMD_W), .PTR_W(PTR_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .we(rx_we), .addr(rx_addr), .wdata(rx_wdata),
      .full(full), .cmd_q(cmd_q), .ptr_q(ptr_q), .release_o(release_s),
      .rx_en(rx_en), .rdata(rx_rdata));

   assign rx_irq = full & rx_en;
   assign tx_irq = ~full & tx_en;

   // R10
   collision_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && release_s && tx_we && tx_addr == mbx_pkg::TX_OFS_CMD) |=> !full);
   // R5
   rx_irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq) |-> ($past(commit) || $past(rx_we)));
endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_we = 1'b0, rx_we = 1'b0;
   logic [1:0]  tx_addr = '0, rx_addr = '0;
   logic [31:0] tx_wdata = '0, rx_wdata = '0;
   logic [31:0] tx_rdata, rx_rdata;
   logic        tx_irq, rx_irq;
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ipc_mailbox i_ipc_mailbox (
      .clk(clk), .rst_n(rst_n),
      .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata), .tx_rdata(tx_rdata), .tx_irq(tx_irq),
      .rx_we(rx_we), .rx_addr(rx_addr), .rx_wdata(rx_wdata), .rx_rdata(rx_rdata), .rx_irq(rx_irq));

   typedef struct packed {
      logic [1:0]  wside;  // 0 none, 1 sender, 2 receiver
      logic [1:0]  waddr;
      logic [31:0] wdata;
      logic        rside;  // 0 sender, 1 receiver
      logic [1:0]  raddr;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{2'd1, 2'd0, 32'h1000, 1'b1, 2'd2, 32'h0,    4'd3},  // R3 pointer alone
      '{2'd1, 2'd0, 32'h2000, 1'b0, 2'd0, 32'h2000, 4'd3},  // R3 restage
      '{2'd1, 2'd1, 32'h0005, 1'b1, 2'd2, 32'h1,    4'd4},  // R4 pending bit
      '{2'd0, 2'd0, 32'h0,    1'b1, 2'd0, 32'h2000, 4'd2},  // R2 pointer
      '{2'd0, 2'd0, 32'h0,    1'b1, 2'd1, 32'h5,    4'd2},  // R2 command
      '{2'd1, 2'd1, 32'h0009, 1'b0, 2'd2, 32'h3,    4'd7},  // R7 ovf
      '{2'd1, 2'd0, 32'h3000, 1'b1, 2'd0, 32'h2000, 4'd7},  // R7 held ptr
      '{2'd2, 2'd3, 32'h0,    1'b1, 2'd2, 32'h0,    4'd6},  // R6 release
      '{2'd1, 2'd2, 32'h0,    1'b0, 2'd2, 32'h2,    4'd8},  // R8 stays
      '{2'd1, 2'd2, 32'h2,    1'b0, 2'd2, 32'h0,    4'd8},  // R8 clear
      '{2'd1, 2'd0, 32'h44,   1'b0, 2'd0, 32'h44,   4'd3}   // R3 staging again
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] side, input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      if (side == 2'd1) begin tx_we = 1'b1; tx_addr = a; tx_wdata = d; end
      if (side == 2'd2) begin rx_we = 1'b1; rx_addr = a; rx_wdata = d; end
      @(negedge clk);
      tx_we = 1'b0; rx_we = 1'b0;
   endtask

   task automatic rd(input logic side, input logic [1:0] a, output logic [31:0] v);
      if (side) rx_addr = a; else tx_addr = a;
      #1;
      v = side ? rx_rdata : tx_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(1'b0, 2'd2, v); check("R1 tx status", v, 32'h0);
      rd(1'b1, 2'd2, v); check("R1 rx status", v, 32'h0);
      check("R1 irqs", {30'b0, tx_irq, rx_irq}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i].wside, VEC[i].waddr, VEC[i].wdata);
         rd(VEC[i].rside, VEC[i].raddr, v);
         check($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
      end

      // R5 receiver interrupt needs enable and pending
      wr(2'd2, 2'd2, 32'h1);
      check("R5 irq low while empty", {31'b0, rx_irq}, 32'h0);
      rd(1'b1, 2'd2, v); check("R5 enable readback", v, 32'h2);
      wr(2'd1, 2'd1, 32'h7);
      check("R5 irq on pending", {31'b0, rx_irq}, 32'h1);
      wr(2'd2, 2'd3, 32'h0);
      check("R6 irq drops on release", {31'b0, rx_irq}, 32'h0);

      // R9 sender interrupt while free
      check("R9 no irq when disabled", {31'b0, tx_irq}, 32'h0);
      wr(2'd1, 2'd2, 32'h4);
      check("R9 irq when free", {31'b0, tx_irq}, 32'h1);
      wr(2'd1, 2'd1, 32'h8);
      check("R9 irq low when pending", {31'b0, tx_irq}, 32'h0);
      rd(1'b0, 2'd2, v); check("R9 status full+en", v, 32'h5);

      // R10 command and release in one cycle while pending
      @(negedge clk);
      tx_we = 1'b1; tx_addr = 2'd1; tx_wdata = 32'hA;
      rx_we = 1'b1; rx_addr = 2'd3;
      @(negedge clk);
      tx_we = 1'b0; rx_we = 1'b0;
      rd(1'b1, 2'd2, v); check("R10 slot empty", v, 32'h2);
      rd(1'b0, 2'd2, v); check("R10 ovf set, cmd dropped", v, 32'h6);
      check("R10 tx irq free", {31'b0, tx_irq}, 32'h1);
      check("R10 rx irq low", {31'b0, rx_irq}, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule